// File: doc/BRIEF.md
# Parallel Single-Slope Conversion Counter Bank

This block is the digital half of a bank of single-slope converters that share one ramp. Every storage cell of an analog memory has its own comparator. All of them watch the same ramp, and all cells are converted in the same ramp pass. A single fast counter, clocked by a 500 MHz to 2 GHz conversion clock, measures time along the ramp. Each cell has its own register. That register captures the counter the first time its comparator goes high.

A start pulse clears all cell results and restarts the counter at zero. The counter advances in Gray code, so a captured value can be off by at most one step of the count. Captured values are converted to binary on the read path. When the counter reaches full scale, the pass is over. Every cell that has not captured yet is loaded with full scale. A completion flag is then carried into the read clock domain.

Software or a readout sequencer selects a cell with an address and reads its 12-bit result. Results hold until the next accepted start.

Top module: `wramp_adc_bank`

## Requirements
- R1: After reset, done_o is 0 and every cell address reads 0 on rd_data_o.
- R2: A start_i seen high at a clk_i rising edge while no pass is running is accepted at that edge. The accepting edge clears all cell results and loads count 0. The count then steps by exactly one Gray-code bit on each later clk_i edge.
- R3: Let n count the clk_i rising edges after the accepting edge, with n from 1 to 4096. A cell whose comparator input is sampled high at edge n, having been sampled low at the edge before, records the value n-1.
- R4: A cell records only its first rising comparator edge in a pass. Later edges in the same pass, and edges after the pass, leave its result unchanged.
- R5: The pass ends at edge 4096 after the accepting edge. Every cell without a recorded value then holds 4095 (full scale).
- R6: done_o rises after the pass ends, through a two-stage synchronizer clocked by rd_clk_i. It falls again after the next accepted start.
- R7: A start_i that arrives while a pass is running is ignored. The count and the cell results go on as if it had not arrived.
- R8: rd_data_o combinationally shows the binary result of the cell selected by rd_addr_i. Once the pass has ended, each result stays constant until the next accepted start.
- R9: A comparator input that is already high when the pass starts, and stays high, produces no rising edge. That cell reads 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast conversion clock that drives the shared counter |
| rd_clk_i | input | 1 | Read-side clock for the completion flag |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start of a conversion pass (clk_i domain) |
| comp_i | input | N_CELLS (8) | One comparator output per cell, high once the ramp has crossed the cell's voltage |
| rd_addr_i | input | ADDR_W (3) | Cell select for readout |
| rd_data_o | output | CNT_W (12) | Binary result of the selected cell |
| done_o | output | 1 | Pass complete, in the rd_clk_i domain |

## Verification
A wrong captured count or a stuck counter step shows up on rd_data_o on the very clock after the capture edge. The bench sweeps rd_addr_i across the cells on every conversion-clock cycle, so a single off-by-one or a missed capture is caught within a few cycles of the pass. A lost first-edge guard, or an accepted start during a pass, moves a result away from the value its comparator timing predicts. That shows up at the latest in the readout after the pass. A broken end-of-pass fill leaves a cell without its full-scale value. A missing synchronizer stage or done flag shows on done_o within a few read clocks.

// File: rtl/wramp_pkg.sv
package wramp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } conv_state_t;
endpackage

// File: rtl/wramp_gray_cnt.sv
module wramp_gray_cnt #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] gray_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] FULL_G = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] gray_q, bin_w, inc_w, nxt_w;

  always_comb begin
    bin_w[CNT_W-1] = gray_q[CNT_W-1];
    for (int i = CNT_W-2; i >= 0; i--) bin_w[i] = bin_w[i+1] ^ gray_q[i];
    inc_w = bin_w + 1'b1;
    nxt_w = inc_w ^ (inc_w >> 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gray_q <= '0;
    else if (clr_i)  gray_q <= '0;
    else if (en_i)   gray_q <= nxt_w;
  end

  assign gray_o = gray_q;
  assign full_o = (gray_q == FULL_G);

  p_gray_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i && !full_o |=> $countones(gray_q ^ $past(gray_q)) == 1);
endmodule

// File: rtl/wramp_cell.sv
module wramp_cell #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             fill_i,
  input  logic             comp_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] val_o,
  output logic             lat_o
);
  localparam logic [CNT_W-1:0] FULL_G = {1'b1, {(CNT_W-1){1'b0}}};

  logic comp_q, rise;
  assign rise = comp_i & ~comp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) comp_q <= 1'b0;
    else         comp_q <= comp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_o <= '0;
      lat_o <= 1'b0;
    end else if (clr_i) begin
      val_o <= '0;
      lat_o <= 1'b0;
    end else if (!lat_o && run_i && rise) begin
      val_o <= count_i;
      lat_o <= 1'b1;
    end else if (!lat_o && fill_i) begin
      val_o <= FULL_G;
      lat_o <= 1'b1;
    end
  end

  p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && rise && !lat_o && !clr_i |=> lat_o && val_o == $past(count_i));
  p_first_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_o && !clr_i |=> $stable(val_o));
endmodule

// File: rtl/wramp_sync.sv
module wramp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/wramp_adc_bank.sv
module wramp_adc_bank
  import wramp_pkg::*;
#(
  parameter  int unsigned N_CELLS = 8,
  parameter  int unsigned CNT_W   = 12,
  parameter  int unsigned SYNC_N  = 2,
  localparam int unsigned ADDR_W  = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
  input  logic               clk_i,
  input  logic               rd_clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [N_CELLS-1:0] comp_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [CNT_W-1:0]   rd_data_o,
  output logic               done_o
);
  localparam int unsigned NSLOT = 1 << ADDR_W;

  conv_state_t      state_q, state_d;
  logic [CNT_W-1:0] cnt_g;
  logic             cnt_full, accept, run, fill;
  logic [N_CELLS-1:0] lat;
  logic [CNT_W-1:0] cell_g [NSLOT];
  logic [CNT_W-1:0] sel_g, sel_b;

  assign run    = (state_q == ST_RUN);
  assign accept = start_i && !run;
  assign fill   = run && cnt_full;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i) state_d = ST_RUN;
      ST_RUN:           if (cnt_full) state_d = ST_DONE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  wramp_gray_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .en_i   (run && !cnt_full),
    .gray_o (cnt_g),
    .full_o (cnt_full)
  );

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (i < N_CELLS) begin : g_cell
      wramp_cell #(.CNT_W(CNT_W)) u_cell (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (accept),
        .run_i   (run),
        .fill_i  (fill),
        .comp_i  (comp_i[i]),
        .count_i (cnt_g),
        .val_o   (cell_g[i]),
        .lat_o   (lat[i])
      );
    end else begin : g_pad
      assign cell_g[i] = '0;
    end
  end

  // Gray to binary on the read path only
  always_comb begin
    sel_g = cell_g[rd_addr_i];
    sel_b[CNT_W-1] = sel_g[CNT_W-1];
    for (int i = CNT_W-2; i >= 0; i--) sel_b[i] = sel_b[i+1] ^ sel_g[i];
  end
  assign rd_data_o = sel_b;

  wramp_sync #(.STAGES(SYNC_N)) u_done_sync (
    .clk_i  (rd_clk_i),
    .rst_ni (rst_ni),
    .d_i    (state_q == ST_DONE),
    .q_o    (done_o)
  );

  p_all_filled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DONE |-> &lat);
  p_start_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && start_i && !cnt_full |=> run && cnt_g != '0);
  p_read_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DONE && !start_i |=> $stable(rd_data_o) || !$stable(rd_addr_i));
endmodule

// File: tb/wramp_adc_bank_bench.sv
module wramp_adc_bank_bench;
  localparam int N = 8;
  localparam int W = 12;
  localparam int FULL = (1 << W) - 1;

  logic clk_i = 1'b0, rd_clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [N-1:0] comp_i = '0;
  logic [2:0] rd_addr_i = '0;
  logic [W-1:0] rd_data_o;
  logic done_o;

  int tests = 0, fails = 0, cyc = 0;
  int edge_at [N];
  logic [N-1:0] pre_high;
  int mid_start;

  // reference model state
  bit m_run, m_prev [N], m_lat [N];
  int m_cnt, m_val [N];
  bit cmp_en = 1'b0;

  always #2 clk_i = ~clk_i;
  always #12.5 rd_clk_i = ~rd_clk_i;

  wramp_adc_bank u_wramp_adc_bank (
    .clk_i(clk_i), .rd_clk_i(rd_clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .comp_i(comp_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .done_o(done_o)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run = 0; m_cnt = 0;
      for (int c = 0; c < N; c++) begin m_prev[c] = 0; m_lat[c] = 0; m_val[c] = 0; end
    end else begin
      if (m_run) begin
        for (int c = 0; c < N; c++)
          if (comp_i[c] && !m_prev[c] && !m_lat[c]) begin m_val[c] = m_cnt; m_lat[c] = 1; end
        if (m_cnt == FULL) begin
          for (int c = 0; c < N; c++) if (!m_lat[c]) begin m_val[c] = FULL; m_lat[c] = 1; end
          m_run = 0;
        end else m_cnt++;
      end else if (start_i) begin
        m_run = 1; m_cnt = 0;
        for (int c = 0; c < N; c++) begin m_lat[c] = 0; m_val[c] = 0; end
      end
      for (int c = 0; c < N; c++) m_prev[c] = comp_i[c];
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison of the selected cell (R3, R8)
  always begin
    @(negedge clk_i);
    #1;
    if (cmp_en) check("R8 per-clock read", int'(rd_data_o), m_val[rd_addr_i]);
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R5 watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int expect_val(input int c);
    if (pre_high[c]) return FULL;
    if (edge_at[c] >= 1 && edge_at[c] <= 4096) return edge_at[c] - 1;
    return FULL;
  endfunction

  task automatic read_all(input string req);
    for (int c = 0; c < N; c++) begin
      @(negedge clk_i);
      rd_addr_i = 3'(c);
      #1;
      check(req, int'(rd_data_o), expect_val(c));
    end
  endtask

  task automatic run_pass;
    @(negedge clk_i);
    start_i = 1'b1;
    comp_i = pre_high;
    for (int j = 1; j <= 4140; j++) begin
      @(negedge clk_i);
      start_i = (mid_start != 0 && j == mid_start);
      rd_addr_i = 3'(j % N);
      for (int c = 0; c < N; c++) begin
        if (edge_at[c] > 0) begin
          if (j == edge_at[c])     comp_i[c] = 1'b1;
          if (j == edge_at[c] + 3) comp_i[c] = 1'b0; // R4 second pulse follows
          if (j == edge_at[c] + 6) comp_i[c] = 1'b1;
        end
      end
      if (j == 40) check("R6 done cleared after start", int'(done_o), 0);
      if (j == 4000) check("R6 done low while running", int'(done_o), 0);
    end
    check("R6 done raised after pass", int'(done_o), 1);
    read_all("R3/R5 result after pass");
    // R4 R8: comparator activity after the pass leaves results untouched
    @(negedge clk_i);
    comp_i = ~comp_i;
    repeat (5) @(negedge clk_i);
    comp_i = '1;
    repeat (5) @(negedge clk_i);
    comp_i = '0;
    read_all("R4/R8 hold after pass");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    check("R1 done after reset", int'(done_o), 0);
    rd_addr_i = 3'd5; #1;
    check("R1 data after reset", int'(rd_data_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    pre_high = '0;
    for (int c = 0; c < N; c++) begin
      rd_addr_i = 3'(c); #0.2;
      check("R1 cell reads zero", int'(rd_data_o), 0);
    end
    repeat (40) @(negedge clk_i);
    check("R1 done idle", int'(done_o), 0);
    cmp_en = 1'b1;

    // R3 R5: spread of edges incl. first slot, last slot, too late, never
    edge_at = '{1, 5, 100, 0, 4096, 4097, 2000, 3};
    pre_high = '0; mid_start = 0;
    run_pass();

    // R7: start during the pass is ignored; R2 second pass restarts from 0
    edge_at = '{10, 1200, 30, 40, 50, 60, 1500, 80};
    mid_start = 1000;
    run_pass();

    // R9: comparators high before start never fire
    edge_at = '{0, 7, 0, 4095, 9, 11, 13, 4000};
    pre_high = 8'b0000_0101;
    mid_start = 0;
    run_pass();

    cmp_en = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule